// File: doc/BRIEF.md
# Self-Timed Program Cycle Controller

This block sits behind the serial command front-end of a small word-organised nonvolatile memory. When the front-end has shifted in a complete program command, it presents a one-cycle request carrying the target address, the data word and a flag that selects a whole-array fill. The controller then runs a self-timed program cycle on its own.

Each word is first cleared to all ones. A second timed phase follows, and only then is the new data committed through a single-word write port to the array. Both phase lengths are parameters counted in clock cycles, so the real millisecond program time maps onto any system clock. The array fill visits every address in ascending order inside one busy period.

A ready/busy line reports progress whatever the chip select does. While chip select is low, the same status also appears on the shared serial data output. After a cycle ends, that output holds a ready '1' until the host clocks in a '1'. A high level on the abort input stops a running cycle at once. It also blocks a request that arrives while it is high.

Top module: `selftimed_write_ctrl`

## Requirements
- R1: A request (wr_req_i high for one cycle) is accepted only while the block is idle and abort_i is low; rdy_o is low from the cycle after acceptance; a request raised while busy is ignored and causes no array write.
- R2: For a single-word program, the first busy cycle drives mem_we_o with mem_wdata_o all ones at the target address; exactly CLR_CYC+WR_CYC cycles later mem_we_o writes the latched data word there; rdy_o returns high CLR_CYC+WR_CYC+1 cycles after acceptance.
- R3: rdy_o is 1 whenever no cycle runs and does not depend on cs_n_i.
- R4: While a cycle runs and cs_n_i is low, do_oe_o is 1 and do_o is 0; with cs_n_i high do_oe_o is 0.
- R5: After a cycle has ended, with cs_n_i low do_oe_o is 1 and do_o is 1; this holds, even across deselection, until a bit_stb_i pulse with di_i=1 and cs_n_i low, after which do_oe_o is 0. Before any cycle since reset, do_oe_o stays 0.
- R6: abort_i high in any busy cycle makes rdy_o high from the next cycle, and with cs_n_i low do_o shows 1 with do_oe_o high.
- R7: An abort during the clear phase leaves the target word all ones; an abort during the write phase or in the commit cycle itself leaves it all ones and commits no data.
- R8: A request in a cycle where abort_i is high starts nothing: rdy_o stays 1, no array write occurs and do_oe_o stays 0.
- R9: With wr_all_i set, addresses 0 to 2^ADDR_W-1 are each cleared then written with the same word in ascending order, in one busy period of 2^ADDR_W*(CLR_CYC+WR_CYC+1) cycles.
- R10: An abort during a fill stops it: words already finished keep the new data, the word in progress is all ones (abort in its clear phase) and later words are untouched.
- R11: After reset rdy_o is 1, mem_we_o is 0 and do_oe_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_req_i | input | 1 | One-cycle program request from the front-end |
| wr_all_i | input | 1 | With wr_req_i: fill every address |
| wr_addr_i | input | ADDR_W | Target address of a single-word program |
| wr_data_i | input | DATA_W | Data word to program |
| abort_i | input | 1 | Abort level; high stops or blocks a cycle |
| cs_n_i | input | 1 | Active-low chip select |
| bit_stb_i | input | 1 | One-cycle strobe per serial clock rising edge |
| di_i | input | 1 | Serial data input level |
| rdy_o | output | 1 | 1 ready, 0 busy |
| do_o | output | 1 | Status value for the shared serial output |
| do_oe_o | output | 1 | Drive enable for the shared serial output |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_wdata_o | output | DATA_W | Array write data |

## Verification
Single-word programs to distinct addresses with distinct data confirm the clear-then-commit order and the exact busy length. A second request raised mid-cycle shows that the block ignores it. Aborts are placed in the clear phase, in the write phase and in the commit cycle itself, so that an abort that is late by one cycle would still write data and be seen. A full-array fill checks address order and total duration. A second fill aborted partway separates finished, interrupted and untouched words. Chip select and data-in strobes are toggled around a cycle to show when the status output is driven and when it is released.

// File: rtl/stw_pkg.sv
package stw_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_CLEAR  = 2'd1,
      ST_WRITE  = 2'd2,
      ST_COMMIT = 2'd3
   } stw_state_e;

   typedef enum logic {
      PH_CLEAR = 1'b0,
      PH_WRITE = 1'b1
   } stw_phase_e;
endpackage

// File: rtl/stw_phase_timer.sv
module stw_phase_timer
   import stw_pkg::*;
#(
   parameter int CLR_CYC = 12,
   parameter int WR_CYC  = 20
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load_i,
   input  stw_phase_e phase_i,
   output logic       expired_o,
   output logic       fresh_o
);
   localparam int MAXC = (CLR_CYC > WR_CYC) ? CLR_CYC : WR_CYC;
   localparam int CW   = (MAXC > 2) ? $clog2(MAXC) : 1;
   localparam logic [CW-1:0] CLR_LD = CW'(CLR_CYC - 1);
   localparam logic [CW-1:0] WR_LD  = CW'(WR_CYC - 1);

   logic [CW-1:0] cnt_q;
   logic          fresh_q;

   initial begin
      assert (CLR_CYC >= 2) else $error("CLR_CYC must be at least 2");
      assert (WR_CYC >= 2) else $error("WR_CYC must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         fresh_q <= 1'b0;
      end else begin
         fresh_q <= load_i;
         if (load_i) begin
            cnt_q <= (phase_i == PH_CLEAR) ? CLR_LD : WR_LD;
         end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign expired_o = (cnt_q == '0);
   assign fresh_o   = fresh_q;

   // R2: a freshly loaded phase never ends in its first cycle
   a_r2_load_not_expired: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> !expired_o);
endmodule

// File: rtl/stw_addr_seq.sv
module stw_addr_seq #(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] start_i,
   input  logic              step_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              last_o
);
   localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

   logic [ADDR_W-1:0] addr_q;

   initial begin
      assert (ADDR_W >= 1 && ADDR_W <= 16) else $error("ADDR_W out of range");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (load_i) begin
         addr_q <= start_i;
      end else if (step_i && addr_q != LAST_ADDR) begin
         addr_q <= addr_q + 1'b1;
      end
   end

   assign addr_o = addr_q;
   assign last_o = (addr_q == LAST_ADDR);

   // R9: the fill moves to the next higher address on each step
   a_r9_ascending_step: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i && !last_o) |=> (addr_o == $past(addr_o) + 1'b1));
endmodule

// File: rtl/stw_status_drv.sv
module stw_status_drv #(
   parameter bit DO_PIPE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic busy_i,
   input  logic start_i,
   input  logic end_i,
   input  logic cs_n_i,
   input  logic bit_stb_i,
   input  logic di_i,
   output logic do_o,
   output logic do_oe_o
);
   logic done_q;
   logic oe_c;
   logic val_c;
   logic release_c;

   assign release_c = done_q && !busy_i && !cs_n_i && bit_stb_i && di_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_q <= 1'b0;
      end else if (start_i) begin
         done_q <= 1'b0;
      end else if (end_i) begin
         done_q <= 1'b1;
      end else if (release_c) begin
         done_q <= 1'b0;
      end
   end

   assign oe_c  = !cs_n_i && (busy_i || done_q);
   assign val_c = !busy_i;

   generate
      if (DO_PIPE) begin : g_pipe
         logic do_q;
         logic oe_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               do_q <= 1'b0;
               oe_q <= 1'b0;
            end else begin
               do_q <= val_c;
               oe_q <= oe_c;
            end
         end
         assign do_o    = do_q;
         assign do_oe_o = oe_q;
      end else begin : g_comb
         assign do_o    = val_c;
         assign do_oe_o = oe_c;
      end
   endgenerate

   // R5: the end of a cycle shows ready on the data line when selected
   a_r5_ready_after_end: assert property (@(posedge clk) disable iff (!rst_n)
      end_i |=> (cs_n_i || (oe_c && val_c)));

   // R5: a clocked-in '1' releases the line
   a_r5_release_on_one: assert property (@(posedge clk) disable iff (!rst_n)
      (release_c && !start_i) |=> !oe_c || busy_i);
endmodule

// File: rtl/selftimed_write_ctrl.sv
module selftimed_write_ctrl
   import stw_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 16,
   parameter int CLR_CYC = 12,
   parameter int WR_CYC  = 20,
   parameter bit DO_PIPE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req_i,
   input  logic              wr_all_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              abort_i,
   input  logic              cs_n_i,
   input  logic              bit_stb_i,
   input  logic              di_i,
   output logic              rdy_o,
   output logic              do_o,
   output logic              do_oe_o,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o
);
   localparam logic [DATA_W-1:0] ERASED = {DATA_W{1'b1}};

   stw_state_e        state_q;
   logic              sweep_q;
   logic [DATA_W-1:0] data_q;
   logic              busy;
   logic              accept;
   logic              expired;
   logic              fresh;
   logic              last;
   logic              more;
   logic              tmr_load;
   stw_phase_e        tmr_phase;
   logic              step;
   logic              cycle_end;
   logic [ADDR_W-1:0] cur_addr;

   initial begin
      assert (DATA_W >= 1 && DATA_W <= 64) else $error("DATA_W out of range");
   end

   assign busy      = (state_q != ST_IDLE);
   assign accept    = !busy && wr_req_i && !abort_i;
   assign more      = sweep_q && !last;
   assign step      = (state_q == ST_COMMIT) && more && !abort_i;
   assign tmr_load  = accept
                    || ((state_q == ST_CLEAR) && expired && !abort_i)
                    || step;
   assign tmr_phase = (state_q == ST_CLEAR) ? PH_WRITE : PH_CLEAR;
   assign cycle_end = busy && (abort_i || ((state_q == ST_COMMIT) && !more));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         sweep_q <= 1'b0;
         data_q  <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  state_q <= ST_CLEAR;
                  sweep_q <= wr_all_i;
                  data_q  <= wr_data_i;
               end
            end
            ST_CLEAR: begin
               if (abort_i)      state_q <= ST_IDLE;
               else if (expired) state_q <= ST_WRITE;
            end
            ST_WRITE: begin
               if (abort_i)      state_q <= ST_IDLE;
               else if (expired) state_q <= ST_COMMIT;
            end
            ST_COMMIT: begin
               if (abort_i || !more) state_q <= ST_IDLE;
               else                  state_q <= ST_CLEAR;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   stw_phase_timer #(
      .CLR_CYC (CLR_CYC),
      .WR_CYC  (WR_CYC)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (tmr_load),
      .phase_i   (tmr_phase),
      .expired_o (expired),
      .fresh_o   (fresh)
   );

   stw_addr_seq #(
      .ADDR_W (ADDR_W)
   ) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (accept),
      .start_i (wr_all_i ? '0 : wr_addr_i),
      .step_i  (step),
      .addr_o  (cur_addr),
      .last_o  (last)
   );

   stw_status_drv #(
      .DO_PIPE (DO_PIPE)
   ) u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .busy_i    (busy),
      .start_i   (accept),
      .end_i     (cycle_end),
      .cs_n_i    (cs_n_i),
      .bit_stb_i (bit_stb_i),
      .di_i      (di_i),
      .do_o      (do_o),
      .do_oe_o   (do_oe_o)
   );

   assign rdy_o       = !busy;
   assign mem_we_o    = ((state_q == ST_CLEAR) && fresh)
                      || ((state_q == ST_COMMIT) && !abort_i);
   assign mem_addr_o  = cur_addr;
   assign mem_wdata_o = (state_q == ST_COMMIT) ? data_q : ERASED;

   // R1: an accepted request turns busy and starts with a clear write
   a_r1_accept_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && wr_req_i && !abort_i) |=> (!rdy_o && mem_we_o && mem_wdata_o == ERASED));

   // R6: abort while busy shows ready on the next cycle
   a_r6_abort_to_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && abort_i) |=> rdy_o);

   // R7: no data is committed in a cycle where abort is high
   a_r7_no_commit_on_abort: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we_o && abort_i) |-> (mem_wdata_o == ERASED));

   // R8: a request blocked by abort leaves the block idle
   a_r8_blocked_request: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && abort_i) |=> (rdy_o && !mem_we_o));
endmodule

// File: tb/selftimed_write_ctrl_tb.sv
module selftimed_write_ctrl_tb;
   localparam int AW    = 8;
   localparam int DW    = 16;
   localparam int C     = 5;
   localparam int W     = 7;
   localparam int PER   = C + W + 1;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_req = 1'b0;
   logic          wr_all = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          abort = 1'b0;
   logic          cs_n = 1'b1;
   logic          bit_stb = 1'b0;
   logic          di = 1'b0;
   logic          rdy, dout, doe, mwe;
   logic [AW-1:0] maddr;
   logic [DW-1:0] mwdata;

   logic [DW-1:0] model [DEPTH];
   int            wr_events = 0;
   int            n_chk = 0;
   int            n_err = 0;

   always #5 clk = ~clk;

   selftimed_write_ctrl #(
      .ADDR_W (AW), .DATA_W (DW), .CLR_CYC (C), .WR_CYC (W), .DO_PIPE (1'b0)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .wr_req_i (wr_req), .wr_all_i (wr_all),
      .wr_addr_i (wr_addr), .wr_data_i (wr_data), .abort_i (abort),
      .cs_n_i (cs_n), .bit_stb_i (bit_stb), .di_i (di), .rdy_o (rdy),
      .do_o (dout), .do_oe_o (doe), .mem_we_o (mwe), .mem_addr_o (maddr),
      .mem_wdata_o (mwdata)
   );

   always @(posedge clk) begin
      if (mwe) begin
         model[maddr] <= mwdata;
         wr_events    <= wr_events + 1;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] got,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   // Drives a request at the current falling edge; returns at index 0
   task automatic start_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                              input bit all);
      wr_req = 1'b1; wr_addr = a; wr_data = d; wr_all = all;
      @(negedge clk);
      wr_req = 1'b0; wr_all = 1'b0;
   endtask

   task automatic wait_ready(output int cycles);
      cycles = 1;
      while (!rdy && cycles < 20000) begin
         @(negedge clk);
         if (!rdy) cycles++;
      end
   endtask

   task automatic release_line();
      cs_n = 1'b0; di = 1'b1; bit_stb = 1'b1;
      @(negedge clk);
      bit_stb = 1'b0; di = 1'b0; cs_n = 1'b1;
   endtask

   task automatic t_reset();
      chk(rdy == 1'b1, "R11 rdy after reset", 32'(rdy), 1);
      chk(mwe == 1'b0, "R11 no write after reset", 32'(mwe), 0);
      cs_n = 1'b0; #1;
      chk(doe == 1'b0, "R5 R11 line released before any cycle", 32'(doe), 0);
      cs_n = 1'b1;
   endtask

   task automatic t_blocked_request();
      int ev0;
      ev0 = wr_events;
      cs_n = 1'b0; abort = 1'b1;
      start_write(8'h03, 16'h1234, 1'b0);
      abort = 1'b0;
      chk(rdy == 1'b1, "R8 request under abort stays ready", 32'(rdy), 1);
      chk(doe == 1'b0, "R8 line stays released", 32'(doe), 0);
      @(negedge clk);
      chk(wr_events == ev0, "R8 no array write", 32'(wr_events), 32'(ev0));
      cs_n = 1'b1;
   endtask

   task automatic t_single_write();
      int n, commit_at;
      bit do_bad;
      logic [DW-1:0] cv;
      commit_at = -1; do_bad = 1'b0; cv = '0;
      start_write(8'h5A, 16'hC3A5, 1'b0);
      chk(rdy == 1'b0, "R1 busy after accept", 32'(rdy), 0);
      chk(mwe && maddr == 8'h5A && mwdata == 16'hFFFF, "R2 clear write first",
          {7'd0, mwe, maddr, mwdata}, {7'd0, 1'b1, 8'h5A, 16'hFFFF});
      chk(doe == 1'b0, "R4 deselected line released while busy", 32'(doe), 0);
      chk(rdy == 1'b0, "R3 busy regardless of select", 32'(rdy), 0);
      cs_n = 1'b0;
      n = 1;
      forever begin
         @(negedge clk);
         if (rdy) break;
         n++;
         if (!(doe && !dout)) do_bad = 1'b1;
         if (mwe) begin commit_at = n - 1; cv = mwdata; end
         if (n > 1000) break;
      end
      chk(n == PER, "R2 busy length", 32'(n), 32'(PER));
      chk(commit_at == C + W, "R2 commit cycle", 32'(commit_at), 32'(C + W));
      chk(cv == 16'hC3A5, "R2 committed data", 32'(cv), 32'hC3A5);
      chk(!do_bad, "R4 busy shown as 0 on line", 32'(do_bad), 0);
      chk(model[8'h5A] == 16'hC3A5, "R2 array content", 32'(model[8'h5A]), 32'hC3A5);
      chk(doe && dout, "R5 ready 1 shown after end", {30'd0, doe, dout}, 32'd3);
      cs_n = 1'b1; #1;
      chk(doe == 1'b0, "R4 deselect releases line", 32'(doe), 0);
      chk(rdy == 1'b1, "R3 ready while deselected", 32'(rdy), 1);
      @(negedge clk);
      cs_n = 1'b0; di = 1'b0; bit_stb = 1'b1;
      @(negedge clk);
      bit_stb = 1'b0;
      chk(doe && dout, "R5 held after reselect and a 0 bit", {30'd0, doe, dout}, 32'd3);
      di = 1'b1; bit_stb = 1'b1;
      @(negedge clk);
      bit_stb = 1'b0; di = 1'b0;
      chk(doe == 1'b0, "R5 released by a 1 bit", 32'(doe), 0);
      cs_n = 1'b1;
   endtask

   task automatic t_ignore_while_busy();
      int ev0, n;
      ev0 = wr_events;
      start_write(8'h10, 16'h1111, 1'b0);
      @(negedge clk);
      @(negedge clk);
      wr_req = 1'b1; wr_addr = 8'h20; wr_data = 16'h2222;
      @(negedge clk);
      wr_req = 1'b0;
      wait_ready(n);
      @(negedge clk);
      chk(wr_events == ev0 + 2, "R1 second request ignored", 32'(wr_events), 32'(ev0 + 2));
      chk(model[8'h10] == 16'h1111, "R1 first request data", 32'(model[8'h10]), 32'h1111);
      chk(rdy == 1'b1, "R1 idle after ignored request", 32'(rdy), 1);
      release_line();
   endtask

   task automatic t_abort_at(input logic [AW-1:0] a, input logic [DW-1:0] d,
                             input int idx, input string tag);
      int ev0;
      start_write(a, d, 1'b0);
      for (int i = 1; i <= idx; i++) @(negedge clk);
      ev0 = wr_events;
      abort = 1'b1; cs_n = 1'b0;
      @(negedge clk);
      abort = 1'b0;
      chk(rdy == 1'b1, {"R6 ready after abort ", tag}, 32'(rdy), 1);
      chk(doe && dout, {"R6 ready on line ", tag}, {30'd0, doe, dout}, 32'd3);
      @(negedge clk);
      chk(model[a] == 16'hFFFF, {"R7 word erased ", tag}, 32'(model[a]), 32'hFFFF);
      chk(wr_events == ev0, {"R7 no data commit ", tag}, 32'(wr_events), 32'(ev0));
      release_line();
   endtask

   task automatic t_sweep();
      int n, ev;
      bit bad;
      logic [DW-1:0] ed;
      n = 1; ev = 1; bad = 1'b0;
      start_write(8'h77, 16'h6B6B, 1'b1);
      if (!(mwe && maddr == 0 && mwdata == 16'hFFFF)) bad = 1'b1;
      forever begin
         @(negedge clk);
         if (rdy) break;
         n++;
         if (mwe) begin
            ed = (ev % 2) ? 16'h6B6B : 16'hFFFF;
            if (maddr != AW'(ev / 2) || mwdata != ed) bad = 1'b1;
            ev++;
         end
         if (n > 20000) break;
      end
      chk(n == DEPTH * PER, "R9 fill busy length", 32'(n), 32'(DEPTH * PER));
      chk(ev == 2 * DEPTH, "R9 fill write count", 32'(ev), 32'(2 * DEPTH));
      chk(!bad, "R9 ascending clear-then-data order", 32'(bad), 0);
      @(negedge clk);
      bad = 1'b0;
      for (int k = 0; k < DEPTH; k++) if (model[k] != 16'h6B6B) bad = 1'b1;
      chk(!bad, "R9 whole array filled", 32'(bad), 0);
      release_line();
   endtask

   task automatic t_sweep_abort();
      int stop_word;
      stop_word = 40;
      start_write(8'h00, 16'h9494, 1'b1);
      for (int i = 1; i <= stop_word * PER + 2; i++) @(negedge clk);
      abort = 1'b1;
      @(negedge clk);
      abort = 1'b0;
      chk(rdy == 1'b1, "R10 fill stops on abort", 32'(rdy), 1);
      @(negedge clk);
      chk(model[stop_word - 1] == 16'h9494, "R10 finished word new",
          32'(model[stop_word - 1]), 32'h9494);
      chk(model[0] == 16'h9494, "R10 first word new", 32'(model[0]), 32'h9494);
      chk(model[stop_word] == 16'hFFFF, "R10 interrupted word erased",
          32'(model[stop_word]), 32'hFFFF);
      chk(model[stop_word + 1] == 16'h6B6B, "R10 later word untouched",
          32'(model[stop_word + 1]), 32'h6B6B);
      chk(model[DEPTH - 1] == 16'h6B6B, "R10 last word untouched",
          32'(model[DEPTH - 1]), 32'h6B6B);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_blocked_request();
      t_single_write();
      t_ignore_while_busy();
      t_abort_at(8'h5A, 16'h0F0F, 2, "in clear");
      t_abort_at(8'h10, 16'hABCD, C + 2, "in write phase");
      t_abort_at(8'h11, 16'h5555, C + W, "in commit cycle");
      t_sweep();
      t_sweep_abort();
      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule